// File: doc/BRIEF.md
# Checksum-Accumulate Instruction Byte Decoder

This block watches an instruction byte stream that arrives one byte per cycle, qualified by a valid strobe. It picks out the encodings of the checksum-accumulate instruction, which folds a source operand into a running CRC over the polynomial 0x11EDC6F41. For each encoding it finds, it reports the width of the source operand and whether the destination register is 64 bits wide. When the encoding is well formed but must not execute, because of a bus-lock prefix, a repeat prefix or a cleared feature-enable input, it raises an invalid-opcode pulse in place of the match pulse.

The accepted grammar has four parts, in order:
- A run of legacy prefix bytes. It must include F2 and may include F0 (bus lock), F3 (repeat) and 66 (operand size).
- An optional width-extension byte in the range 40 to 4F. It is recognized only when the wide-mode input is high.
- The two-byte escape 0F 38.
- An opcode byte, F0 or F1, followed by one ModRM byte.

The decoder signals its result while the ModRM byte is taken. It keeps that byte on an output. A build parameter can move the result pulses one register later.

Top module: `crcacc_decoder`

## Requirements
- R1: After a prefix run that includes F2, then 0F, 38, F0 or F1, and one more byte (the ModRM), the decoder gives a one-cycle pulse on `hit_o`. With `PULSE_REG`=0 the pulse falls in the cycle the ModRM byte is presented. With `PULSE_REG`=1 it falls one cycle later. An extension byte that directly follows the prefix run is allowed only in wide mode.
- R2: `width_o` encodes the source width as 0 = 8 bits, 1 = 16 bits, 2 = 32 bits and 3 = 64 bits. Opcode F0 gives code 0. Opcode F1 with no operand-size prefix and no extension W gives code 2.
- R3: Opcode F1 with a 66 prefix and extension W clear gives code 1, with `dst64_o` low.
- R4: In wide mode, an extension byte 40 to 4F carries W in bit 3. With W set, F1 gives code 3 and F0 gives code 0, and `dst64_o` is high in both cases; W also overrides a 66 prefix. With W clear, `dst64_o` is low.
- R5: When wide mode is low, a byte from 40 to 4F breaks the sequence, so no pulse follows.
- R6: The extension byte must be followed directly by 0F. Any other byte breaks the sequence.
- R7: A recognized encoding that carries an F0 prefix pulses `ud_o` instead of `hit_o`. The two are never high together.
- R8: A recognized encoding that carries an F3 prefix pulses `ud_o` instead of `hit_o`.
- R9: If `feat_en_i` is low in the ModRM cycle, a recognized encoding pulses `ud_o` instead of `hit_o`.
- R10: Without an F2 prefix, 0F 38 F0/F1 plus a following byte gives no pulse.
- R11: A byte that breaks the sequence returns the decoder to its idle state, clears every prefix it has collected, and is itself dropped rather than taken as a new prefix. `modrm_o` keeps its earlier value.
- R12: Up to `PFX_MAX` legacy prefix bytes are accepted. One more prefix byte breaks the sequence in the same way as R11.
- R13: `modrm_o` shows the ModRM byte from the pulse cycle onward and holds it until the next recognized encoding. While `vld_i` is low the decoder holds its position in the sequence.
- R14: During and just after reset, `hit_o`, `ud_o`, `width_o`, `dst64_o` and `modrm_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_i | input | BYTE_W | Instruction stream byte |
| vld_i | input | 1 | `byte_i` holds a byte this cycle |
| wide_mode_i | input | 1 | Enables recognition of the 40 to 4F extension byte |
| feat_en_i | input | 1 | Instruction feature enable; sampled in the ModRM cycle |
| hit_o | output | 1 | Legal encoding recognized (pulse) |
| ud_o | output | 1 | Encoding recognized but illegal (pulse) |
| width_o | output | 2 | Source width code of the current encoding |
| dst64_o | output | 1 | Destination is 64 bits |
| modrm_o | output | BYTE_W | Captured ModRM byte |

## Verification
The bench builds two copies of the decoder side by side, one with `PULSE_REG`=0 and one with `PULSE_REG`=1, and feeds both the same stream. It checks that the registered copy reports the same events one cycle later, with the same captured ModRM byte. `PFX_MAX` is set to 4, so a run of four F2 bytes still decodes and a fifth makes the prefix count overflow in a short vector. The table vectors cover both settings of wide mode and feature enable, and a stalled sequence checks that the decoder holds its state while `vld_i` is low.

// File: rtl/crcdec_pkg.sv
`timescale 1ns/1ps
package crcdec_pkg;

   typedef enum logic [2:0] {
      ST_PFX  = 3'd0,
      ST_ESC0 = 3'd1,
      ST_ESC1 = 3'd2,
      ST_OPC  = 3'd3,
      ST_MRM  = 3'd4
   } seq_st_e;

   typedef enum logic [1:0] {
      WID_8  = 2'd0,
      WID_16 = 2'd1,
      WID_32 = 2'd2,
      WID_64 = 2'd3
   } src_wid_e;

   typedef struct packed {
      logic lock;
      logic rep;
      logic sel;
      logic osz;
   } pfx_flags_t;

   localparam logic [7:0] B_LOCK  = 8'hF0;
   localparam logic [7:0] B_SEL   = 8'hF2;
   localparam logic [7:0] B_REP   = 8'hF3;
   localparam logic [7:0] B_OSZ   = 8'h66;
   localparam logic [7:0] B_ESC_A = 8'h0F;
   localparam logic [7:0] B_ESC_B = 8'h38;
   localparam logic [7:0] B_OP8   = 8'hF0;
   localparam logic [7:0] B_OPW   = 8'hF1;
   localparam logic [3:0] EXT_HI  = 4'h4;

   function automatic logic is_legacy_pfx(input logic [7:0] b);
      return (b == B_LOCK) || (b == B_SEL) || (b == B_REP) || (b == B_OSZ);
   endfunction

   function automatic src_wid_e pick_width(input logic opc_lsb,
                                           input logic ext_w,
                                           input logic osz);
      src_wid_e w;
      if (!opc_lsb)   w = WID_8;
      else if (ext_w) w = WID_64;
      else if (osz)   w = WID_16;
      else            w = WID_32;
      return w;
   endfunction

endpackage

// File: rtl/crcdec_pfx_trk.sv
`timescale 1ns/1ps
module crcdec_pfx_trk
   import crcdec_pkg::*;
#(
   parameter int BYTE_W  = 8,
   parameter int PFX_MAX = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              take_i,
   input  logic [BYTE_W-1:0] byte_i,
   output pfx_flags_t        flags_o,
   output logic              full_o
);
   localparam int CNT_W = $clog2(PFX_MAX + 1);

   logic [CNT_W-1:0] cnt_q;
   pfx_flags_t       flags_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clr_i) begin
         cnt_q   <= '0;
         flags_q <= '0;
      end else if (take_i) begin
         cnt_q <= cnt_q + CNT_W'(1);
         if (byte_i[7:0] == B_LOCK) flags_q.lock <= 1'b1;
         if (byte_i[7:0] == B_REP)  flags_q.rep  <= 1'b1;
         if (byte_i[7:0] == B_SEL)  flags_q.sel  <= 1'b1;
         if (byte_i[7:0] == B_OSZ)  flags_q.osz  <= 1'b1;
      end
   end

   assign flags_o = flags_q;
   assign full_o  = (cnt_q == CNT_W'(PFX_MAX));

endmodule

// File: rtl/crcdec_seq.sv
`timescale 1ns/1ps
module crcdec_seq
   import crcdec_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vld_i,
   input  logic [BYTE_W-1:0] byte_i,
   input  logic              wide_i,
   input  logic              sel_seen_i,
   input  logic              pfx_full_i,
   output logic              pfx_take_o,
   output logic              pfx_clr_o,
   output logic              op_ld_o,
   output logic              fire_o,
   output logic              ext_w_o
);
   seq_st_e    st_q, st_d;
   logic       ext_w_q;
   logic       ext_set;
   logic [7:0] b;

   assign b = byte_i[7:0];

   always_comb begin
      st_d       = st_q;
      pfx_take_o = 1'b0;
      pfx_clr_o  = 1'b0;
      op_ld_o    = 1'b0;
      fire_o     = 1'b0;
      ext_set    = 1'b0;
      if (vld_i) begin
         case (st_q)
            ST_PFX: begin
               if (is_legacy_pfx(b)) begin
                  if (pfx_full_i) pfx_clr_o  = 1'b1;
                  else            pfx_take_o = 1'b1;
               end else if (wide_i && b[7:4] == EXT_HI) begin
                  ext_set = 1'b1;
                  st_d    = ST_ESC0;
               end else if (b == B_ESC_A) begin
                  st_d = ST_ESC1;
               end else begin
                  pfx_clr_o = 1'b1;
               end
            end
            ST_ESC0: begin
               if (b == B_ESC_A) st_d = ST_ESC1;
               else begin
                  pfx_clr_o = 1'b1;
                  st_d      = ST_PFX;
               end
            end
            ST_ESC1: begin
               if (b == B_ESC_B) st_d = ST_OPC;
               else begin
                  pfx_clr_o = 1'b1;
                  st_d      = ST_PFX;
               end
            end
            ST_OPC: begin
               if ((b == B_OP8 || b == B_OPW) && sel_seen_i) begin
                  op_ld_o = 1'b1;
                  st_d    = ST_MRM;
               end else begin
                  pfx_clr_o = 1'b1;
                  st_d      = ST_PFX;
               end
            end
            ST_MRM: begin
               fire_o    = 1'b1;
               pfx_clr_o = 1'b1;
               st_d      = ST_PFX;
            end
            default: begin
               pfx_clr_o = 1'b1;
               st_d      = ST_PFX;
            end
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= ST_PFX;
         ext_w_q <= 1'b0;
      end else begin
         st_q <= st_d;
         if (pfx_clr_o)    ext_w_q <= 1'b0;
         else if (ext_set) ext_w_q <= b[3];
      end
   end

   assign ext_w_o = ext_w_q;

endmodule

// File: rtl/crcdec_out.sv
`timescale 1ns/1ps
module crcdec_out
   import crcdec_pkg::*;
#(
   parameter int BYTE_W    = 8,
   parameter int PULSE_REG = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BYTE_W-1:0] byte_i,
   input  logic              op_ld_i,
   input  logic              fire_i,
   input  logic              ext_w_i,
   input  logic              osz_i,
   input  logic              bad_i,
   output logic              hit_o,
   output logic              ud_o,
   output logic [1:0]        width_o,
   output logic              dst64_o,
   output logic [BYTE_W-1:0] modrm_o
);
   src_wid_e          wid_q;
   logic              dst_q;
   logic [BYTE_W-1:0] modrm_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wid_q   <= WID_8;
         dst_q   <= 1'b0;
         modrm_q <= '0;
      end else begin
         if (op_ld_i) begin
            wid_q <= pick_width(byte_i[0], ext_w_i, osz_i);
            dst_q <= ext_w_i;
         end
         if (fire_i) modrm_q <= byte_i;
      end
   end

   assign width_o = wid_q;
   assign dst64_o = dst_q;

   generate
      if (PULSE_REG == 0) begin : g_comb
         assign hit_o   = fire_i & ~bad_i;
         assign ud_o    = fire_i &  bad_i;
         assign modrm_o = fire_i ? byte_i : modrm_q;
      end else begin : g_reg
         logic hit_q, ud_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               hit_q <= 1'b0;
               ud_q  <= 1'b0;
            end else begin
               hit_q <= fire_i & ~bad_i;
               ud_q  <= fire_i &  bad_i;
            end
         end
         assign hit_o   = hit_q;
         assign ud_o    = ud_q;
         assign modrm_o = modrm_q;
      end
   endgenerate

endmodule

// File: rtl/crcacc_decoder.sv
`timescale 1ns/1ps
module crcacc_decoder
   import crcdec_pkg::*;
#(
   parameter int BYTE_W    = 8,
   parameter int PFX_MAX   = 4,
   parameter int PULSE_REG = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BYTE_W-1:0] byte_i,
   input  logic              vld_i,
   input  logic              wide_mode_i,
   input  logic              feat_en_i,
   output logic              hit_o,
   output logic              ud_o,
   output logic [1:0]        width_o,
   output logic              dst64_o,
   output logic [BYTE_W-1:0] modrm_o
);
   initial begin
      assert (BYTE_W == 8) else $error("BYTE_W must be 8");
      assert (PFX_MAX >= 1 && PFX_MAX <= 15) else $error("PFX_MAX out of range");
      assert (PULSE_REG == 0 || PULSE_REG == 1) else $error("PULSE_REG must be 0 or 1");
   end

   pfx_flags_t flags;
   logic       pfx_full, pfx_take, pfx_clr, op_ld, fire, ext_w, bad;

   crcdec_pfx_trk #(.BYTE_W(BYTE_W), .PFX_MAX(PFX_MAX)) u_pfx (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (pfx_clr),
      .take_i  (pfx_take),
      .byte_i  (byte_i),
      .flags_o (flags),
      .full_o  (pfx_full)
   );

   crcdec_seq #(.BYTE_W(BYTE_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .vld_i      (vld_i),
      .byte_i     (byte_i),
      .wide_i     (wide_mode_i),
      .sel_seen_i (flags.sel),
      .pfx_full_i (pfx_full),
      .pfx_take_o (pfx_take),
      .pfx_clr_o  (pfx_clr),
      .op_ld_o    (op_ld),
      .fire_o     (fire),
      .ext_w_o    (ext_w)
   );

   assign bad = flags.lock | flags.rep | ~feat_en_i;

   crcdec_out #(.BYTE_W(BYTE_W), .PULSE_REG(PULSE_REG)) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .byte_i  (byte_i),
      .op_ld_i (op_ld),
      .fire_i  (fire),
      .ext_w_i (ext_w),
      .osz_i   (flags.osz),
      .bad_i   (bad),
      .hit_o   (hit_o),
      .ud_o    (ud_o),
      .width_o (width_o),
      .dst64_o (dst64_o),
      .modrm_o (modrm_o)
   );

endmodule

// File: rtl/crcdec_chk.sv
`timescale 1ns/1ps
module crcdec_chk #(
   parameter int BYTE_W    = 8,
   parameter int PULSE_REG = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              feat_en_i,
   input logic              hit_o,
   input logic              ud_o,
   input logic [1:0]        width_o,
   input logic              dst64_o,
   input logic [BYTE_W-1:0] modrm_o
);
   // R1: a match is a single-cycle pulse
   a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      hit_o |=> !hit_o);

   // R7: match and fault never coincide
   a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(hit_o && ud_o));

   // R4: a 64-bit source always comes with a 64-bit destination
   a_r4_wide_dst: assert property (@(posedge clk) disable iff (!rst_n)
      ((hit_o || ud_o) && width_o == 2'd3) |-> dst64_o);

   // R3: 16- and 32-bit sources never report a 64-bit destination
   a_r3_narrow_dst: assert property (@(posedge clk) disable iff (!rst_n)
      ((hit_o || ud_o) && (width_o == 2'd1 || width_o == 2'd2)) |-> !dst64_o);

   // R13: captured ModRM only moves with an event pulse
   a_r13_modrm_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(hit_o || ud_o) |-> $stable(modrm_o));

   generate
      if (PULSE_REG == 0) begin : g_comb
         // R9: a match requires the feature enable in the ModRM cycle
         a_r9_feat_gate: assert property (@(posedge clk) disable iff (!rst_n)
            hit_o |-> feat_en_i);
      end else begin : g_reg
         // R9: registered variant looks one cycle back
         a_r9_feat_gate: assert property (@(posedge clk) disable iff (!rst_n)
            hit_o |-> $past(feat_en_i));
      end
   endgenerate

endmodule

bind crcacc_decoder crcdec_chk #(.BYTE_W(BYTE_W), .PULSE_REG(PULSE_REG)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .feat_en_i (feat_en_i),
   .hit_o     (hit_o),
   .ud_o      (ud_o),
   .width_o   (width_o),
   .dst64_o   (dst64_o),
   .modrm_o   (modrm_o)
);

// File: tb/crcacc_decoder_bench.sv
`timescale 1ns/1ps
module crcacc_decoder_bench;
   localparam int PMAX = 4;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic       rst_n, vld_i, wide_i, feat_i;
   logic [7:0] byte_i;
   logic       h0, u0, d0, h1, u1, d1;
   logic [1:0] w0, w1;
   logic [7:0] m0, m1;

   crcacc_decoder #(.BYTE_W(8), .PFX_MAX(PMAX), .PULSE_REG(0)) u_crcacc_decoder (
      .clk(clk), .rst_n(rst_n), .byte_i(byte_i), .vld_i(vld_i),
      .wide_mode_i(wide_i), .feat_en_i(feat_i),
      .hit_o(h0), .ud_o(u0), .width_o(w0), .dst64_o(d0), .modrm_o(m0));

   crcacc_decoder #(.BYTE_W(8), .PFX_MAX(PMAX), .PULSE_REG(1)) u_crcacc_decoder_q (
      .clk(clk), .rst_n(rst_n), .byte_i(byte_i), .vld_i(vld_i),
      .wide_mode_i(wide_i), .feat_en_i(feat_i),
      .hit_o(h1), .ud_o(u1), .width_o(w1), .dst64_o(d1), .modrm_o(m1));

   // monitor: samples each cycle just after inputs settle
   int         cyc = 0;
   int         nh0 = 0, nu0 = 0, nh1 = 0, nu1 = 0, c0 = 0, c1 = 0;
   logic [1:0] cw0 = '0;
   logic       cd0 = 1'b0;
   logic [7:0] cm0 = '0, cm1 = '0;
   always begin
      @(negedge clk);
      #1;
      cyc++;
      if (h0 || u0) begin
         if (h0) nh0++;
         if (u0) nu0++;
         cw0 = w0; cd0 = d0; cm0 = m0; c0 = cyc;
      end
      if (h1 || u1) begin
         if (h1) nh1++;
         if (u1) nu1++;
         cm1 = m1; c1 = cyc;
      end
   end

   int errs = 0, checks = 0;

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic push(input logic [7:0] b);
      @(negedge clk);
      byte_i = b;
      vld_i  = 1'b1;
   endtask

   task automatic idle(input int n);
      repeat (n) begin
         @(negedge clk);
         vld_i  = 1'b0;
         byte_i = 8'h00;
      end
   endtask

   typedef struct packed {
      logic [63:0] seq;   // bytes sent left to right
      logic [3:0]  len;
      logic        wide;
      logic        feat;
      logic        hit;
      logic        ud;
      logic [1:0]  wid;
      logic        dst;
      logic [7:0]  mrm;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 19;
   localparam vec_t TAB [NV] = '{
      '{64'hF20F38F1C1000000, 4'd5, 1'b0, 1'b1, 1'b1, 1'b0, 2'd2, 1'b0, 8'hC1, 8'd1 },  // R1 R2
      '{64'hF20F38F0D3000000, 4'd5, 1'b0, 1'b1, 1'b1, 1'b0, 2'd0, 1'b0, 8'hD3, 8'd2 },  // R2
      '{64'h66F20F38F10A0000, 4'd6, 1'b0, 1'b1, 1'b1, 1'b0, 2'd1, 1'b0, 8'h0A, 8'd3 },  // R3
      '{64'hF2480F38F1C80000, 4'd6, 1'b1, 1'b1, 1'b1, 1'b0, 2'd3, 1'b1, 8'hC8, 8'd4 },  // R4
      '{64'hF24C0F38F0110000, 4'd6, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0, 1'b1, 8'h11, 8'd4 },  // R4
      '{64'hF2440F38F1220000, 4'd6, 1'b1, 1'b1, 1'b1, 1'b0, 2'd2, 1'b0, 8'h22, 8'd4 },  // R4
      '{64'h66F2480F38F13300, 4'd7, 1'b1, 1'b1, 1'b1, 1'b0, 2'd3, 1'b1, 8'h33, 8'd4 },  // R4
      '{64'hF2480F38F1440000, 4'd6, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 8'h00, 8'd5 },  // R5
      '{64'hF248660F38F15500, 4'd7, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 8'h00, 8'd6 },  // R6
      '{64'hF0F20F38F1660000, 4'd6, 1'b0, 1'b1, 1'b0, 1'b1, 2'd2, 1'b0, 8'h66, 8'd7 },  // R7
      '{64'hF3F20F38F0770000, 4'd6, 1'b0, 1'b1, 1'b0, 1'b1, 2'd0, 1'b0, 8'h77, 8'd8 },  // R8
      '{64'hF20F38F188000000, 4'd5, 1'b0, 1'b0, 1'b0, 1'b1, 2'd2, 1'b0, 8'h88, 8'd9 },  // R9
      '{64'h0F38F19900000000, 4'd4, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 8'h00, 8'd10},  // R10
      '{64'hF20F370F38F1AA00, 4'd7, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 8'h00, 8'd11},  // R11
      '{64'hF2F2F2F20F38F1BB, 4'd8, 1'b0, 1'b1, 1'b1, 1'b0, 2'd2, 1'b0, 8'hBB, 8'd12},  // R12 at limit
      '{64'hF2F2F2F2F20F38F1, 4'd8, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 8'h00, 8'd12},  // R12 over limit
      '{64'hF20FF20F38F1CC00, 4'd7, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 8'h00, 8'd11},  // R11 dropped byte
      '{64'hF20F38F1DD000000, 4'd5, 1'b1, 1'b1, 1'b1, 1'b0, 2'd2, 1'b0, 8'hDD, 8'd1 },  // R1 wide, no ext
      '{64'hF0F2480F38F1EE00, 4'd7, 1'b1, 1'b1, 1'b0, 1'b1, 2'd3, 1'b1, 8'hEE, 8'd7 }   // R7 with ext
   };

   task automatic run_vec(input vec_t v);
      int         bh0, bu0, bh1, bu1;
      logic [7:0] prev_m;
      string      rq;
      rq     = $sformatf("R%0d", v.req);
      bh0 = nh0; bu0 = nu0; bh1 = nh1; bu1 = nu1;
      prev_m = m0;
      wide_i = v.wide;
      feat_i = v.feat;
      for (int i = 0; i < int'(v.len); i++) push(v.seq[63 - 8*i -: 8]);
      idle(3);
      chk(rq, "hit count", nh0 - bh0, int'(v.hit));
      chk(rq, "ud count",  nu0 - bu0, int'(v.ud));
      chk(rq, "registered hit count", nh1 - bh1, int'(v.hit));  // R1 registered variant
      chk(rq, "registered ud count",  nu1 - bu1, int'(v.ud));
      if (v.hit || v.ud) begin
         chk(rq, "width code", int'(cw0), int'(v.wid));
         chk(rq, "dst64", int'(cd0), int'(v.dst));
         chk(rq, "modrm in pulse", int'(cm0), int'(v.mrm));
         chk(rq, "modrm held", int'(m0), int'(v.mrm));          // R13
         chk("R1", "registered delay", c1 - c0, 1);
         chk("R1", "registered modrm", int'(cm1), int'(v.mrm));
      end else begin
         chk(rq, "modrm untouched", int'(m0), int'(prev_m));   // R11
      end
   endtask

   task automatic summary;
      $display("Result: errors=%0d of %0d checks", errs, checks);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errs++;
      $display("FAIL watchdog: actual=expired expected=finished");
      summary();
      $finish;
   end

   initial begin
      int bh;
      rst_n = 1'b0; vld_i = 1'b0; byte_i = 8'h00; wide_i = 1'b0; feat_i = 1'b1;
      repeat (4) @(negedge clk);
      #1;
      // R14: reset state
      chk("R14", "hit in reset", int'(h0 | h1), 0);
      chk("R14", "ud in reset", int'(u0 | u1), 0);
      chk("R14", "width in reset", int'(w0), 0);
      chk("R14", "dst64 in reset", int'(d0), 0);
      chk("R14", "modrm in reset", int'(m0), 0);
      @(negedge clk);
      rst_n = 1'b1;
      idle(2);
      chk("R14", "modrm after reset", int'(m0 | m1), 0);
      chk("R14", "no event after reset", nh0 + nu0 + nh1 + nu1, 0);

      for (int i = 0; i < NV; i++) run_vec(TAB[i]);

      // R13: gaps in vld_i stall the sequence without losing it
      bh = nh0;
      wide_i = 1'b0; feat_i = 1'b1;
      push(8'hF2); idle(3);
      push(8'h0F); idle(1);
      push(8'h38); idle(2);
      push(8'hF1); idle(4);
      push(8'h5A); idle(3);
      chk("R13", "stalled hit count", nh0 - bh, 1);
      chk("R13", "stalled modrm", int'(m0), 8'h5A);
      idle(5);
      chk("R13", "modrm held idle", int'(m0), 8'h5A);
      chk("R13", "registered modrm held", int'(m1), 8'h5A);

      summary();
      $finish;
   end

endmodule